// File: doc/BRIEF.md
# Linked-Page Transmit Record Walker

This engine sits on the device side of a host transmit ring. The ring is a set of fixed-size pages in local memory, and each page starts on a page boundary. The host writes message records into the ring. After each message it writes once to a request register, which adds one to a pending-message count. While the count is nonzero, the engine reads the size header of the record at its read pointer. A message record is presented on a descriptor port as its start address and byte size. When the downstream side accepts it, the pointer moves past it and the count drops by one.

The read pointer never wraps by address arithmetic. A page ends with a link record that carries the address of the next page. The engine reads that address, jumps to the start of the page it names, and raises a link flag that the host sees in bit 16 of an interrupt status word. A halt bit in the control register keeps the engine stopped. Clearing it restarts the engine from the programmed base page. A header that is malformed or that would run past the end of its page stops the engine with a fault indication.

Top module: `txr_fetch`

## Requirements
- R1: After reset the halt bit is set, the interrupt enable is clear, and the outputs are at rest: no memory read, no descriptor offered, an interrupt status of zero, no interrupt request and no fault.
- R2: Register 0 is the control-set register and register 1 is the control-clear register. A write to either changes only the control bits written as 1; bit 0 is halt and bit 1 is interrupt enable.
- R3: Clearing halt starts the walk at the page-aligned base address. The base is written at register 3, and the low log2(page size) bits of that address are ignored.
- R4: Each write to register 2 with data bit 0 set adds one pending message. The engine offers exactly one descriptor per pending message and reads nothing while the count is zero.
- R5: A record header is the 32-bit little-endian word at the read pointer: the size is in bits 15:0 and the type is in bits 31:16. A message descriptor carries the record's address and size, and the next record is read at that address plus that size.
- R6: Once offered, a descriptor keeps its valid, address and size unchanged until it is accepted with msg_ready.
- R7: A record of type 0x1001 and size 12 is a link record. The engine takes the next page from the word at offset 4, with its low page-offset bits ignored, and continues there. The link does not use up a pending message.
- R8: Consuming a link record sets a flag shown at bit 16 of irq_status. irq is that flag ANDed with the interrupt enable, and any write to register 4 clears the flag.
- R9: The engine faults and offers nothing further in four cases: a size of zero, a size that is not a multiple of 4, a record that would cross the end of its page, or a link type whose size is not 12. The fault persists until halt is set and cleared again.
- R10: While halt is set, the pending count is held at zero and request writes are ignored. Setting halt withdraws any descriptor on offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register index |
| reg_wdata | input | 32 | register write data |
| mem_re | output | 1 | memory read request |
| mem_addr | output | ADDR_W | byte address of the word to read |
| mem_rdata | input | 32 | read data, valid one cycle after mem_re |
| msg_valid | output | 1 | message descriptor on offer |
| msg_ready | input | 1 | downstream accepts the descriptor |
| msg_addr | output | ADDR_W | start address of the message record |
| msg_size | output | 16 | byte size of the message record |
| irq_status | output | 32 | interrupt status word, link flag at bit 16 |
| irq | output | 1 | interrupt request |
| fault | output | 1 | walk stopped on a malformed record |

## Verification
The main function is driven with four request patterns:
- No pending requests, to show the engine stays quiet.
- A single request, to show it does not run ahead.
- A burst of two requests with the consumer stalled, to show the descriptor holds and the sizes chain correctly.
- A request whose next record is a link, to show that the page jump spends no request and raises the status bit.

Malformed headers are placed at an unaligned size, at a zero size and straddling the page end, so each fault cause is seen separately. Halting during an offer and then restarting separates a true restart from the base from a resumed walk.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // register indices on the write port
  localparam logic [2:0] RA_CTL_SET = 3'd0;
  localparam logic [2:0] RA_CTL_CLR = 3'd1;
  localparam logic [2:0] RA_REQ     = 3'd2;
  localparam logic [2:0] RA_BASE    = 3'd3;
  localparam logic [2:0] RA_ACK     = 3'd4;

  localparam logic [15:0] LINK_TYPE = 16'h1001;
  localparam logic [15:0] LINK_SIZE = 16'd12;

  typedef enum logic [2:0] {
    W_HALT, W_IDLE, W_HDR, W_LINK, W_OFFER, W_FAULT
  } walk_state_t;

  // a record is legal when it is non-empty, word-multiple and ends inside its page
  function automatic logic rec_fits(input logic [31:0] off,
                                    input logic [15:0] sz,
                                    input logic [31:0] page_bytes);
    logic [31:0] end_pos;
    end_pos = off + {16'd0, sz};
    return (sz != 16'd0) && (sz[1:0] == 2'b00) && (end_pos <= page_bytes);
  endfunction

  function automatic logic is_link(input logic [15:0] ty);
    return ty == LINK_TYPE;
  endfunction
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              link_evt,
  input  logic              consume,
  output logic              halt,
  output logic              ien,
  output logic [ADDR_W-1:0] base,
  output logic              pend_nz,
  output logic              link_flag
);
  logic [PEND_W-1:0] pend;
  logic wr_set, wr_clr, wr_req, wr_base, wr_ack;
  logic unused_wdata;

  assign wr_set  = we && (addr == RA_CTL_SET);
  assign wr_clr  = we && (addr == RA_CTL_CLR);
  assign wr_req  = we && (addr == RA_REQ) && wdata[0];
  assign wr_base = we && (addr == RA_BASE);
  assign wr_ack  = we && (addr == RA_ACK);
  assign unused_wdata = ^wdata[31:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b1;
      ien  <= 1'b0;
    end else if (wr_set) begin
      halt <= halt | wdata[0];
      ien  <= ien  | wdata[1];
    end else if (wr_clr) begin
      halt <= halt & ~wdata[0];
      ien  <= ien  & ~wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base <= '0;
    else if (wr_base) base <= wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else if (halt) pend <= '0;
    else pend <= pend + PEND_W'(wr_req) - PEND_W'(consume);
  end
  assign pend_nz = (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_flag <= 1'b0;
    else if (link_evt) link_flag <= 1'b1;
    else if (wr_ack) link_flag <= 1'b0;
  end

  // R4
  consume_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> pend != '0);
  // R8
  link_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> link_flag);
  // R10
  halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> pend == '0);
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic [ADDR_W-1:0] base,
  input  logic              pend_nz,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [15:0]       msg_size,
  output logic              link_evt,
  output logic              consume,
  output logic              fault
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  walk_state_t state;
  logic [ADDR_W-1:0] ptr;
  logic [15:0] size_q;
  logic [15:0] hdr_size, hdr_type;
  logic hdr_ok, hdr_link;
  logic [31:0] ptr_off;
  logic unused_rd;

  assign hdr_size = mem_rdata[15:0];
  assign hdr_type = mem_rdata[31:16];
  assign ptr_off  = {{(32-PG_W){1'b0}}, ptr[PG_W-1:0]};
  assign hdr_ok   = rec_fits(ptr_off, hdr_size, 32'(PAGE_BYTES));
  assign hdr_link = is_link(hdr_type);
  assign unused_rd = ^{mem_rdata[31:ADDR_W], mem_rdata[PG_W-1:0]};

  assign mem_re = !halt && (((state == W_IDLE) && pend_nz) ||
                            ((state == W_HDR) && hdr_ok && hdr_link &&
                             (hdr_size == LINK_SIZE)));
  assign mem_addr  = (state == W_HDR) ? ptr + ADDR_W'(4) : ptr;
  assign msg_valid = (state == W_OFFER) && !halt;
  assign msg_addr  = ptr;
  assign msg_size  = size_q;
  assign link_evt  = (state == W_LINK) && !halt;
  assign consume   = msg_valid && msg_ready;
  assign fault     = (state == W_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= W_HALT;
      ptr    <= '0;
      size_q <= '0;
    end else if (halt) begin
      state <= W_HALT;
      ptr   <= {base[ADDR_W-1:PG_W], {PG_W{1'b0}}};
    end else begin
      unique case (state)
        W_HALT: state <= W_IDLE;
        W_IDLE: if (pend_nz) state <= W_HDR;
        W_HDR: begin
          if (!hdr_ok) state <= W_FAULT;
          else if (hdr_link) state <= (hdr_size == LINK_SIZE) ? W_LINK : W_FAULT;
          else begin
            size_q <= hdr_size;
            state  <= W_OFFER;
          end
        end
        W_LINK: begin
          ptr   <= {mem_rdata[ADDR_W-1:PG_W], {PG_W{1'b0}}};
          state <= W_IDLE;
        end
        W_OFFER: if (msg_ready) begin
          ptr   <= ptr + ADDR_W'(size_q);
          state <= W_IDLE;
        end
        W_FAULT: state <= W_FAULT;
        default: state <= W_HALT;
      endcase
    end
  end

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !msg_valid && !mem_re);
  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> halt ||
      (msg_valid && $stable(msg_addr) && $stable(msg_size)));
  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !halt |=> fault);
  // R9
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_size != 16'd0) && (msg_size[1:0] == 2'b00));
  // R7
  link_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> msg_addr[PG_W-1:0] == '0);
endmodule

// File: rtl/txr_fetch.sv
module txr_fetch
  import txr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 2048,
  parameter int PEND_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [15:0]       msg_size,
  output logic [31:0]       irq_status,
  output logic              irq,
  output logic              fault
);
  logic halt, ien, pend_nz, link_flag, link_evt, consume;
  logic [ADDR_W-1:0] base;

  txr_regs #(.ADDR_W(ADDR_W), .PEND_W(PEND_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .link_evt(link_evt), .consume(consume), .halt(halt), .ien(ien),
    .base(base), .pend_nz(pend_nz), .link_flag(link_flag)
  );

  txr_walker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .halt(halt), .base(base), .pend_nz(pend_nz),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_size(msg_size), .link_evt(link_evt), .consume(consume), .fault(fault)
  );

  assign irq_status = {15'd0, link_flag, 16'd0};
  assign irq        = link_flag & ien;

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_status[16]);
endmodule

// File: tb/txr_fetch_test.sv
module txr_fetch_test;
  localparam int ADDR_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_re;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic msg_valid;
  logic msg_ready = 1'b0;
  logic [ADDR_W-1:0] msg_addr;
  logic [15:0] msg_size;
  logic [31:0] irq_status;
  logic irq, fault;

  logic [31:0] mem [0:2047];
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  txr_fetch uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_size(msg_size), .irq_status(irq_status),
    .irq(irq), .fault(fault)
  );

  // local memory model, one cycle read latency
  always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr[ADDR_W-1:2]];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic put(input int byte_addr, input logic [15:0] ty, input logic [15:0] sz);
    mem[byte_addr >> 2] = {ty, sz};
  endtask

  task automatic wait_msg(input int max, output bit got);
    got = 1'b0;
    for (int i = 0; i < max && !got; i++) begin
      @(negedge clk);
      if (msg_valid) got = 1'b1;
    end
  endtask

  task automatic expect_none(input int cycles, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check(!seen, req, 32'(seen), 32'd0);
  endtask

  task automatic restart(input logic [31:0] b);
    wr(3'd0, 32'd1);
    wr(3'd3, b);
    wr(3'd1, 32'd1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!mem_re && !msg_valid, "R1 quiet", {30'd0, mem_re, msg_valid}, 0);
    check(irq_status == 0, "R1 status", irq_status, 0);
    check(!irq && !fault, "R1 irq/fault", {30'd0, irq, fault}, 0);
  endtask

  task automatic t_halt_ignore;
    put(0, 16'h0022, 16'd8);
    wr(3'd2, 32'd1);
    wr(3'd2, 32'd1);
    wr(3'd1, 32'd1);
    expect_none(10, "R10 requests while halted");
  endtask

  task automatic t_basic;
    bit got;
    bit held;
    restart(32'h923);
    put(12'h800, 16'h0022, 16'd8);
    put(12'h808, 16'h0022, 16'd16);
    put(12'h818, 16'h0022, 16'd12);
    expect_none(8, "R4 zero pending");
    msg_ready = 1'b1;
    wr(3'd2, 32'd1);
    wait_msg(20, got);
    check(got && msg_addr == 13'h800, "R3 base aligned", 32'(msg_addr), 32'h800);
    check(msg_size == 16'd8, "R5 size", 32'(msg_size), 8);
    expect_none(8, "R4 one per request");
    msg_ready = 1'b0;
    wr(3'd2, 32'd1);
    wr(3'd2, 32'd1);
    wait_msg(20, got);
    check(got && msg_addr == 13'h808 && msg_size == 16'd16, "R5 next record",
          32'(msg_addr), 32'h808);
    held = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (!msg_valid || msg_addr != 13'h808 || msg_size != 16'd16) held = 1'b0;
    end
    check(held, "R6 hold under stall", 32'(held), 1);
    msg_ready = 1'b1;
    wait_msg(20, got);
    check(got && msg_addr == 13'h818 && msg_size == 16'd12, "R5 chain",
          32'(msg_addr), 32'h818);
    @(negedge clk);
  endtask

  task automatic t_link;
    bit got;
    wr(3'd0, 32'd2);
    put(12'h824, 16'h1001, 16'd12);
    mem[12'h828 >> 2] = 32'h0000_0005;
    mem[12'h82C >> 2] = 32'h0;
    put(0, 16'h0033, 16'd20);
    msg_ready = 1'b1;
    wr(3'd2, 32'd1);
    wait_msg(30, got);
    check(got && msg_addr == 13'h000 && msg_size == 16'd20, "R7 link jump",
          32'(msg_addr), 0);
    @(negedge clk);
    check(irq_status == 32'h0001_0000, "R8 status bit16", irq_status, 32'h10000);
    check(irq == 1'b1, "R8 irq with enable", 32'(irq), 1);
    wr(3'd1, 32'd2);
    check(irq == 1'b0 && irq_status == 32'h0001_0000, "R2 clear enable only",
          {irq_status[31:1], irq}, 32'h10000);
    expect_none(8, "R7 link spends no request");
    wr(3'd4, 32'd0);
    check(irq_status == 0, "R8 ack", irq_status, 0);
  endtask

  task automatic t_fault;
    bit got;
    put(12'h014, 16'h0000, 16'd6);
    wr(3'd2, 32'd1);
    expect_none(10, "R9 unaligned size no offer");
    check(fault, "R9 unaligned size", 32'(fault), 1);
    restart(32'h800);
    put(12'h800, 16'h0000, 16'h07F8);
    put(12'hFF8, 16'h0000, 16'd16);
    @(negedge clk);
    check(!fault, "R9 cleared by restart", 32'(fault), 0);
    msg_ready = 1'b1;
    wr(3'd2, 32'd1);
    wait_msg(20, got);
    check(got && msg_size == 16'h07F8, "R9 full-page record legal", 32'(msg_size), 32'h7F8);
    wr(3'd2, 32'd1);
    expect_none(10, "R9 crossing no offer");
    check(fault, "R9 page crossing", 32'(fault), 1);
    restart(32'h0);
    put(0, 16'h0000, 16'd0);
    wr(3'd2, 32'd1);
    repeat (8) @(negedge clk);
    check(fault, "R9 zero size", 32'(fault), 1);
  endtask

  task automatic t_halt_mid;
    bit got;
    restart(32'h0);
    put(0, 16'h0044, 16'd8);
    msg_ready = 1'b0;
    wr(3'd2, 32'd1);
    wait_msg(20, got);
    check(got && msg_addr == 0, "R10 offer before halt", 32'(msg_addr), 0);
    wr(3'd0, 32'd1);
    check(!msg_valid, "R10 halt withdraws", 32'(msg_valid), 0);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd1);
    msg_ready = 1'b1;
    wait_msg(20, got);
    check(got && msg_addr == 0 && msg_size == 16'd8, "R3 restart from base",
          32'(msg_addr), 0);
    expect_none(8, "R10 halt dropped pending");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_halt_ignore();
    t_basic();
    t_link();
    t_fault();
    t_halt_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule